// File: doc/BRIEF.md
# SDRAM Bank Timing Checker

This block is a passive observer for the command bus of an SDRAM device with four internal banks. On every clock edge it decodes chip select, the three command strobes, the bank select and the address. It keeps a model of every bank: whether the bank is idle or active, and which row an activate opened in it. It never drives the bus. It only reports what it sees.

Each bank keeps a saturating counter of the cycles since its last activate. One more counter measures the cycles since the last activate to any bank. The block compares these counters against cycle-count parameters when an activate, a column access or a precharge arrives. It sets one sticky flag for each kind of broken rule. A verification environment or a debug monitor can attach the block to a controller's output and read which timing constraint the controller broke. In this document, the distance between two commands is the difference of their clock-cycle indices, so back-to-back commands are at distance 1.

Top module: `sdram_bank_monitor`

## Requirements
- R1: When cs_n=0, ras_n=0, cas_n=1 and we_n=1 (activate), bank_active[bank_sel] reads 1 from the next cycle, and open_row[bank_sel] takes the value of addr.
- R2: When cs_n=0, ras_n=0, cas_n=1, we_n=0 and addr[10]=0 (precharge), only bank bank_sel returns to idle. With addr[10]=1 (precharge all), every bank returns to idle.
- R3: While cs_n=1, the strobes have no effect on bank_active, open_row or viol.
- R4: An activate to a bank that is already active sets viol[0].
- R5: A read (cs_n=0, ras_n=1, cas_n=0, we_n=1) or a write (the same strobes with we_n=0) to an idle bank sets viol[1].
- R6: A read or write to an active bank at a distance below T_RCD from that bank's activate sets viol[2]. A distance of exactly T_RCD is legal.
- R7: Two activates to the same bank at a distance below T_RC set viol[3]. A distance of exactly T_RC is legal.
- R8: Two consecutive activates to different banks at a distance below T_RRD set viol[4]. A distance of exactly T_RRD is legal.
- R9: A precharge that reaches an active bank at a distance below T_RAS_MIN from its activate sets viol[5].
- R10: A bank that is still active at a distance greater than T_RAS_MAX from its activate sets viol[6]. At a distance of exactly T_RAS_MAX no flag is raised.
- R11: Every viol bit stays set until reset. Reset clears viol, makes every bank idle, clears open_row, and leaves no timing window pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | 2 | Bank select |
| addr | input | 12 | Address bus (row on activate, bit 10 selects precharge all) |
| bank_active | output | 4 | One bit per bank, 1 = active |
| open_row | output | 4x12 | Row latched by the last activate of each bank |
| viol | output | 7 | Sticky flags: 0 double activate, 1 idle access, 2 tRCD, 3 tRC, 4 tRRD, 5 tRAS-min, 6 tRAS-max |

## Verification
Several properties are checked on every cycle:
- an activate opens its bank and latches the row;
- precharge-all idles every bank;
- a deselected bus leaves the bank model unchanged;
- a double activate or an access to an idle bank raises its flag;
- the flags never drop outside reset.

The timing windows depend on counter distances against parameters. Only the bench scenarios can show these, by stepping commands to one cycle below each limit and to exactly the limit. The same holds for the tRAS-max expiry and for the rule that a single-bank precharge leaves the other banks untouched.

// File: rtl/sdtc_pkg.sv
package sdtc_pkg;

    localparam int NB     = 4;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int NV     = 7;

    // violation flag positions
    localparam int V_DBL    = 0;
    localparam int V_IDLE   = 1;
    localparam int V_RCD    = 2;
    localparam int V_RC     = 3;
    localparam int V_RRD    = 4;
    localparam int V_RASMIN = 5;
    localparam int V_RASMAX = 6;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_PALL
    } cmd_e;

    typedef struct packed {
        cmd_e              kind;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  addr;
    } bus_cmd_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdtc_decode.sv
module sdtc_decode
    import sdtc_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [ROW_W-1:0]  addr,
    output bus_cmd_t          cmd
);

    always_comb begin
        cmd.bank = bank_sel;
        cmd.addr = addr;
        cmd.kind = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd.kind = CMD_ACT;
                3'b010:  cmd.kind = addr[10] ? CMD_PALL : CMD_PRE;
                3'b101:  cmd.kind = CMD_RD;
                3'b100:  cmd.kind = CMD_WR;
                default: cmd.kind = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdtc_bank.sv
module sdtc_bank
    import sdtc_pkg::*;
#(
    parameter int CW        = 6,
    parameter int CMAX      = 41,
    parameter int T_RCD     = 3,
    parameter int T_RC      = 9,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_acc,
    input  logic [ROW_W-1:0] row_in,
    output logic             active,
    output logic [ROW_W-1:0] row,
    output logic [NV-1:0]    evt
);

    localparam logic [CW-1:0] SAT     = CW'(CMAX);
    localparam logic [CW-1:0] LIM_RCD = CW'(T_RCD);
    localparam logic [CW-1:0] LIM_RC  = CW'(T_RC);
    localparam logic [CW-1:0] LIM_MIN = CW'(T_RAS_MIN);
    localparam logic [CW-1:0] LIM_MAX = CW'(T_RAS_MAX);

    logic [CW-1:0] since_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            row       <= '0;
            since_act <= SAT;
        end else if (do_act) begin
            active    <= 1'b1;
            row       <= row_in;
            since_act <= CW'(1);
        end else begin
            if (since_act != SAT) since_act <= since_act + CW'(1);
            if (do_pre) active <= 1'b0;
        end
    end

    always_comb begin
        evt           = '0;
        evt[V_DBL]    = do_act && active;
        evt[V_IDLE]   = do_acc && !active;
        evt[V_RCD]    = do_acc && active && (since_act < LIM_RCD);
        evt[V_RC]     = do_act && (since_act < LIM_RC);
        evt[V_RASMIN] = do_pre && active && (since_act < LIM_MIN);
        evt[V_RASMAX] = active && (since_act > LIM_MAX);
    end

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sdtc_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RC      = 9,
    parameter int T_RRD     = 2,
    parameter int T_RAS_MIN = 6,
    parameter int T_RAS_MAX = 40
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BANK_W-1:0]         bank_sel,
    input  logic [ROW_W-1:0]          addr,
    output logic [NB-1:0]             bank_active,
    output logic [NB-1:0][ROW_W-1:0]  open_row,
    output logic [NV-1:0]             viol
);

    localparam int CMAX = imax(imax(T_RC, T_RRD), imax(T_RCD, imax(T_RAS_MIN, T_RAS_MAX + 1)));
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] SAT     = CW'(CMAX);
    localparam logic [CW-1:0] LIM_RRD = CW'(T_RRD);

    bus_cmd_t      dc;
    logic [NV-1:0] bank_evt [NB];
    logic [NV-1:0] new_v;
    logic [CW-1:0] since_any;
    logic [BANK_W-1:0] last_bank;
    logic          rrd_evt;

    sdtc_decode u_dec (
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .bank_sel (bank_sel),
        .addr     (addr),
        .cmd      (dc)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = (dc.bank == BANK_W'(b));

        sdtc_bank #(
            .CW        (CW),
            .CMAX      (CMAX),
            .T_RCD     (T_RCD),
            .T_RC      (T_RC),
            .T_RAS_MIN (T_RAS_MIN),
            .T_RAS_MAX (T_RAS_MAX)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .do_act (hit && dc.kind == CMD_ACT),
            .do_pre ((hit && dc.kind == CMD_PRE) || dc.kind == CMD_PALL),
            .do_acc (hit && (dc.kind == CMD_RD || dc.kind == CMD_WR)),
            .row_in (dc.addr),
            .active (bank_active[b]),
            .row    (open_row[b]),
            .evt    (bank_evt[b])
        );
    end

    // spacing between activates of different banks
    always_ff @(posedge clk) begin
        if (rst) begin
            since_any <= SAT;
            last_bank <= '0;
        end else if (dc.kind == CMD_ACT) begin
            since_any <= CW'(1);
            last_bank <= dc.bank;
        end else if (since_any != SAT) begin
            since_any <= since_any + CW'(1);
        end
    end

    assign rrd_evt = (dc.kind == CMD_ACT) && (dc.bank != last_bank) && (since_any < LIM_RRD);

    always_comb begin
        new_v = '0;
        for (int b = 0; b < NB; b++) new_v = new_v | bank_evt[b];
        new_v[V_RRD] = new_v[V_RRD] | rrd_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) viol <= '0;
        else     viol <= viol | new_v;
    end

endmodule

// File: rtl/sdtc_checker.sv
module sdtc_checker
    import sdtc_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     cs_n,
    input logic                     ras_n,
    input logic                     cas_n,
    input logic                     we_n,
    input logic [BANK_W-1:0]        bank_sel,
    input logic [ROW_W-1:0]         addr,
    input logic [NB-1:0]            bank_active,
    input logic [NB-1:0][ROW_W-1:0] open_row,
    input logic [NV-1:0]            viol
);

    logic is_act, is_pall, is_acc;
    assign is_act  = !cs_n && !ras_n && cas_n && we_n;
    assign is_pall = !cs_n && !ras_n && cas_n && !we_n && addr[10];
    assign is_acc  = !cs_n && ras_n && !cas_n;

    p_act_opens_bank_r1: assert property (@(posedge clk) disable iff (rst)
        is_act |=> bank_active[$past(bank_sel)] && (open_row[$past(bank_sel)] == $past(addr)));

    p_prechg_all_idles_r2: assert property (@(posedge clk) disable iff (rst)
        is_pall |=> (bank_active == '0));

    p_deselect_holds_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> $stable(bank_active) && $stable(open_row));

    p_double_act_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (is_act && bank_active[bank_sel]) |=> viol[V_DBL]);

    p_idle_access_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (is_acc && !bank_active[bank_sel]) |=> viol[V_IDLE]);

    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((viol & $past(viol)) == $past(viol)));

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (bank_active == '0) && (viol == '0));

endmodule

bind sdram_bank_monitor sdtc_checker u_chk (.*);

// File: tb/sdram_bank_monitor_tb.sv
module sdram_bank_monitor_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]        bank_sel = '0;
    logic [11:0]       addr = '0;
    logic [3:0]        bank_active;
    logic [3:0][11:0]  open_row;
    logic [6:0]        viol;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sdram_bank_monitor u_dut (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .bank_sel    (bank_sel),
        .addr        (addr),
        .bank_active (bank_active),
        .open_row    (open_row),
        .viol        (viol)
    );

    // {cs,ras,cas,we}, bank, addr, expected active, expected viol
    localparam int NT = 12;
    localparam logic [28:0] TBL [NT] = '{
        {4'b0011, 2'd0, 12'h123, 4'b0001, 7'h00},
        {4'b0111, 2'd0, 12'h000, 4'b0001, 7'h00},
        {4'b0011, 2'd1, 12'h045, 4'b0011, 7'h00},
        {4'b0111, 2'd0, 12'h000, 4'b0011, 7'h00},
        {4'b0101, 2'd0, 12'h000, 4'b0011, 7'h00},
        {4'b0100, 2'd1, 12'h000, 4'b0011, 7'h00},
        {4'b0010, 2'd0, 12'h000, 4'b0010, 7'h00},
        {4'b0111, 2'd0, 12'h000, 4'b0010, 7'h00},
        {4'b0111, 2'd0, 12'h000, 4'b0010, 7'h00},
        {4'b0011, 2'd0, 12'h200, 4'b0011, 7'h00},
        {4'b1011, 2'd2, 12'h300, 4'b0011, 7'h00},
        {4'b0100, 2'd3, 12'h000, 4'b0011, 7'h02}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic drv(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic [11:0] a);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; bank_sel = b; addr = a;
        @(negedge clk);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 12'h0);
    endtask

    task automatic act(input logic [1:0] b, input logic [11:0] r);
        drv(1'b0, 1'b0, 1'b1, 1'b1, b, r);
    endtask

    task automatic pre(input logic [1:0] b);
        drv(1'b0, 1'b0, 1'b1, 1'b0, b, 12'h000);
    endtask

    task automatic do_reset();
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; bank_sel = '0; addr = '0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R11 reset active", 32'(bank_active), 32'h0);
        chk("R11 reset viol", 32'(viol), 32'h0);
        chk("R11 reset rows", 32'(open_row[1]), 32'h0);

        // table walk: legal traffic, deselect, write to idle bank
        for (int i = 0; i < NT; i++) begin
            drv(TBL[i][28], TBL[i][27], TBL[i][26], TBL[i][25], TBL[i][24:23], TBL[i][22:11]);
            chk($sformatf("R1 R2 R5 table step %0d active", i), 32'(bank_active), 32'(TBL[i][10:7]));
            chk($sformatf("R1 R2 R5 table step %0d viol", i), 32'(viol), 32'(TBL[i][6:0]));
        end
        chk("R1 row latched bank0", 32'(open_row[0]), 32'h200);
        chk("R1 row latched bank1", 32'(open_row[1]), 32'h045);

        // R4 double activate
        do_reset();
        act(2'd2, 12'hABC);
        chk("R1 open row bank2", 32'(open_row[2]), 32'hABC);
        nop(10);
        act(2'd2, 12'h111);
        chk("R4 double activate", 32'(viol), 32'h01);

        // R2 single precharge then precharge all
        do_reset();
        act(2'd0, 12'h001);
        nop(2);
        act(2'd3, 12'h002);
        nop(5);
        pre(2'd0);
        chk("R2 single precharge", 32'(bank_active), 32'b1000);
        drv(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 12'h400);
        chk("R2 precharge all", 32'(bank_active), 32'h0);
        chk("R2 no flags", 32'(viol), 32'h0);

        // R3 deselected bus
        do_reset();
        drv(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 12'h055);
        chk("R3 deselected activate", 32'(bank_active), 32'h0);
        drv(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 12'h000);
        chk("R3 deselected read", 32'(viol), 32'h0);
        chk("R3 row untouched", 32'(open_row[0]), 32'h0);

        // R5 read to idle bank
        do_reset();
        drv(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 12'h000);
        chk("R5 read idle bank", 32'(viol), 32'h02);

        // R6 tRCD
        do_reset();
        act(2'd1, 12'h010);
        nop(1);
        drv(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 12'h000);
        chk("R6 early read", 32'(viol), 32'h04);
        do_reset();
        act(2'd1, 12'h010);
        nop(2);
        drv(1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 12'h000);
        chk("R6 write at limit", 32'(viol), 32'h00);

        // R7 tRC
        do_reset();
        act(2'd0, 12'h020);
        nop(5);
        pre(2'd0);
        nop(1);
        act(2'd0, 12'h021);
        chk("R7 early reactivate", 32'(viol), 32'h08);
        do_reset();
        act(2'd0, 12'h020);
        nop(5);
        pre(2'd0);
        nop(2);
        act(2'd0, 12'h021);
        chk("R7 reactivate at limit", 32'(viol), 32'h00);

        // R8 tRRD
        do_reset();
        act(2'd0, 12'h030);
        act(2'd1, 12'h031);
        chk("R8 back-to-back banks", 32'(viol), 32'h10);
        do_reset();
        act(2'd0, 12'h030);
        nop(1);
        act(2'd1, 12'h031);
        chk("R8 banks at limit", 32'(viol), 32'h00);

        // R9 tRAS-min, then R11 stickiness
        do_reset();
        act(2'd0, 12'h040);
        nop(4);
        pre(2'd0);
        chk("R9 early precharge", 32'(viol), 32'h20);
        chk("R9 bank idled", 32'(bank_active), 32'h0);
        nop(3);
        chk("R11 flag sticky", 32'(viol), 32'h20);
        do_reset();
        chk("R11 reset clears flag", 32'(viol), 32'h00);

        // R10 tRAS-max
        do_reset();
        act(2'd0, 12'h050);
        nop(40);
        chk("R10 at limit", 32'(viol), 32'h00);
        nop(1);
        chk("R10 overstay", 32'(viol), 32'h40);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule